// File: doc/BRIEF.md
# Dual-Pair Data Pointer Unit

This block keeps four 24-bit pointers for external data moves, grouped into two pairs. One bit chooses the working pair, and a member bit inside that pair's own control register chooses which of its two pointers drives the address output. A processor core drives the unit through a byte-wide register port and three one-cycle strobes. The first strobe marks an external data access, the second an explicit pointer increment, and the third an increment of the pointer select.

Each pair has its own control register. It can make every access step the active pointer by one, upward or downward, and then flip to the other member of the pair. With both enabled, a copy loop can alternate between a source pointer and a destination pointer and advance each without any extra instructions. An explicit increment also takes a single cycle. All pointer arithmetic wraps modulo 2^24.

Top module: `dptr_unit`

## Requirements
- R1: After reset all four pointers are zero and both control registers read 0x00, so `ptr_idx` is 0 and `addr` is 0.
- R2: Register map on `reg_addr`: addresses 0..11 hold the pointer bytes, pointer k byte b at 3*k+b, with byte 0 the least significant. Address 12 is control register 0 and address 13 is control register 1. A write with `reg_we` takes effect at the next clock edge, and every register reads back combinationally on `reg_rdata`. Addresses 14 and 15 read 0x00, and writes to them change nothing.
- R3: Control bit fields: bit 0 is the member, bit 4 enables stepping on access, bit 5 enables toggling on access, and bit 6 selects decrement. Bit 3 of register 0 selects pair 1. Every other bit, and bit 3 of register 1, reads 0. `ptr_idx` = {pair, member of that pair}, and `addr` is that pointer.
- R4: An access strobe while the active pair has stepping enabled moves the active pointer by one: up when bit 6 is 0, down when it is 1.
- R5: Pointer arithmetic wraps: 0xFFFFFF plus one gives 0x000000, and 0x000000 minus one gives 0xFFFFFF.
- R6: An access strobe while the active pair has toggling enabled flips that pair's member bit. The flip happens after any step, so the step lands on the pointer that was active when the strobe arrived.
- R7: The increment strobe steps the active pointer by one in a single cycle, in the direction given by the active pair's bit 6.
- R8: The select strobe flips the member bit of the active pair only.
- R9: When strobes arrive in the same cycle, their effects apply in this order: the access step, then the access toggle, then the explicit step (on the pointer active after the toggle), then the select flip.
- R10: In a cycle with `reg_we` high, all three strobes are ignored.
- R11: Only the active pair's control bits act. The inactive pair's pointers and member bit stay unchanged while strobes arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| xacc_stb | input | 1 | External data access occurred |
| ptr_inc_stb | input | 1 | Explicit pointer increment |
| sel_inc_stb | input | 1 | Explicit select increment |
| addr | output | 24 | Active pointer value |
| ptr_idx | output | 2 | Active pointer index {pair, member} |

## Verification
Every strobe and every register write changes state at the next rising edge. `addr` and `ptr_idx` are registered, so they show the new values one cycle after the stimulus. `reg_rdata` is combinational from the current state, so a read shows the registers as of the last edge. The bench drives inputs at the falling edge and updates its behavioural model at the rising edge. It compares `addr` and `ptr_idx` at the following falling edge, and it checks register reads after a short settle with no clock in between.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
    localparam int unsigned MEMBER_BIT = 0;
    localparam int unsigned PAIR_BIT   = 3;
    localparam int unsigned STEP_BIT   = 4;
    localparam int unsigned TGL_BIT    = 5;
    localparam int unsigned DEC_BIT    = 6;

    typedef struct packed {
        logic dec;
        logic tgl;
        logic step;
        logic member;
    } pair_ctl_t;

    function automatic pair_ctl_t byte_to_ctl(input logic [7:0] b);
        pair_ctl_t c;
        c.dec    = b[DEC_BIT];
        c.tgl    = b[TGL_BIT];
        c.step   = b[STEP_BIT];
        c.member = b[MEMBER_BIT];
        return c;
    endfunction

    function automatic logic [7:0] ctl_to_byte(input pair_ctl_t c, input logic pair);
        logic [7:0] b;
        b = 8'h00;
        b[DEC_BIT]    = c.dec;
        b[TGL_BIT]    = c.tgl;
        b[STEP_BIT]   = c.step;
        b[MEMBER_BIT] = c.member;
        b[PAIR_BIT]   = pair;
        return b;
    endfunction
endpackage

// File: rtl/dptr_step.sv
module dptr_step #(
    parameter int unsigned W = 24
) (
    input  logic [W-1:0] val,
    input  logic         dec,
    output logic [W-1:0] res
);
    always_comb begin
        if (dec) res = val - W'(1);
        else     res = val + W'(1);
    end
endmodule

// File: rtl/dptr_rdmux.sv
module dptr_rdmux #(
    parameter int unsigned W    = 24,
    parameter int unsigned NPTR = 4,
    parameter int unsigned RA_W = 4
) (
    input  logic [NPTR-1:0][W-1:0] ptrs,
    input  logic [7:0]             ctl0_byte,
    input  logic [7:0]             ctl1_byte,
    input  logic [RA_W-1:0]        raddr,
    output logic [7:0]             rdata
);
    localparam int unsigned BPP = W / 8;
    localparam int unsigned CTL0_A = NPTR * BPP;
    localparam int unsigned CTL1_A = NPTR * BPP + 1;

    always_comb begin
        rdata = 8'h00;
        for (int k = 0; k < int'(NPTR); k++) begin
            for (int b = 0; b < int'(BPP); b++) begin
                if (raddr == RA_W'(k * int'(BPP) + b)) rdata = ptrs[k][b*8 +: 8];
            end
        end
        if (raddr == RA_W'(CTL0_A)) rdata = ctl0_byte;
        if (raddr == RA_W'(CTL1_A)) rdata = ctl1_byte;
    end
endmodule

// File: rtl/dptr_unit.sv
module dptr_unit
    import dptr_pkg::*;
#(
    parameter int unsigned ADDR_W = 24
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    reg_we,
    input  logic [$clog2(4*(ADDR_W/8)+2)-1:0]       reg_addr,
    input  logic [7:0]                              reg_wdata,
    output logic [7:0]                              reg_rdata,
    input  logic                                    xacc_stb,
    input  logic                                    ptr_inc_stb,
    input  logic                                    sel_inc_stb,
    output logic [ADDR_W-1:0]                       addr,
    output logic [1:0]                              ptr_idx
);
    localparam int unsigned NPTR   = 4;
    localparam int unsigned BPP    = ADDR_W / 8;
    localparam int unsigned RA_W   = $clog2(NPTR * BPP + 2);
    localparam int unsigned CTL0_A = NPTR * BPP;
    localparam int unsigned CTL1_A = NPTR * BPP + 1;

    typedef struct packed {
        logic [NPTR-1:0][ADDR_W-1:0] ptr;
        logic                        pair;
        pair_ctl_t [1:0]             ctl;
    } state_t;

    state_t st_d, st_q;

    pair_ctl_t                   act_ctl;
    logic [1:0]                  idx0, idx1;
    logic                        acc_step, acc_tgl, m1, m2;
    logic [ADDR_W-1:0]           step1_res, step2_src, step2_res;
    logic [NPTR-1:0][ADDR_W-1:0] ptr_upd;

    logic unused_wbits;
    assign unused_wbits = ^{reg_wdata[7], reg_wdata[2:1]};

    assign act_ctl  = st_q.ctl[st_q.pair];
    assign idx0     = {st_q.pair, act_ctl.member};
    assign acc_step = xacc_stb & act_ctl.step;
    assign acc_tgl  = xacc_stb & act_ctl.tgl;
    assign m1       = act_ctl.member ^ acc_tgl;
    assign idx1     = {st_q.pair, m1};
    assign m2       = m1 ^ sel_inc_stb;

    dptr_step #(.W(ADDR_W)) u_acc_step (
        .val (st_q.ptr[idx0]),
        .dec (act_ctl.dec),
        .res (step1_res)
    );

    assign step2_src = (acc_step && (idx1 == idx0)) ? step1_res : st_q.ptr[idx1];

    dptr_step #(.W(ADDR_W)) u_inc_step (
        .val (step2_src),
        .dec (act_ctl.dec),
        .res (step2_res)
    );

    always_comb begin
        ptr_upd = st_q.ptr;
        if (acc_step)    ptr_upd[idx0] = step1_res;
        if (ptr_inc_stb) ptr_upd[idx1] = step2_res;
    end

    always_comb begin
        st_d = st_q;
        if (reg_we) begin
            for (int k = 0; k < int'(NPTR); k++) begin
                for (int b = 0; b < int'(BPP); b++) begin
                    if (reg_addr == RA_W'(k * int'(BPP) + b)) st_d.ptr[k][b*8 +: 8] = reg_wdata;
                end
            end
            if (reg_addr == RA_W'(CTL0_A)) begin
                st_d.ctl[0] = byte_to_ctl(reg_wdata);
                st_d.pair   = reg_wdata[PAIR_BIT];
            end
            if (reg_addr == RA_W'(CTL1_A)) st_d.ctl[1] = byte_to_ctl(reg_wdata);
        end else begin
            st_d.ptr                   = ptr_upd;
            st_d.ctl[st_q.pair].member = m2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    dptr_rdmux #(.W(ADDR_W), .NPTR(NPTR), .RA_W(RA_W)) u_rdmux (
        .ptrs      (st_q.ptr),
        .ctl0_byte (ctl_to_byte(st_q.ctl[0], st_q.pair)),
        .ctl1_byte (ctl_to_byte(st_q.ctl[1], 1'b0)),
        .raddr     (reg_addr),
        .rdata     (reg_rdata)
    );

    assign addr    = st_q.ptr[idx0];
    assign ptr_idx = idx0;

    // R2
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr > RA_W'(CTL1_A)) |=> ($stable(addr) && $stable(ptr_idx)));

    // R4
    acc_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xacc_stb && !reg_we && !ptr_inc_stb && !sel_inc_stb &&
         act_ctl.step && !act_ctl.tgl && !act_ctl.dec)
        |=> (addr == $past(addr) + ADDR_W'(1)));

    // R7
    inc_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc_stb && !reg_we && !xacc_stb && !sel_inc_stb && act_ctl.dec)
        |=> (addr == $past(addr) - ADDR_W'(1)));

    // R8
    sel_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_inc_stb && !reg_we && !xacc_stb && !ptr_inc_stb)
        |=> (ptr_idx[0] != $past(ptr_idx[0]) && ptr_idx[1] == $past(ptr_idx[1])));

    // R10
    we_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr > RA_W'(CTL1_A) && (xacc_stb || ptr_inc_stb || sel_inc_stb))
        |=> $stable(st_q));
endmodule

// File: tb/dptr_unit_test.sv
module dptr_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = 4'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       xacc_stb = 1'b0, ptr_inc_stb = 1'b0, sel_inc_stb = 1'b0;
    logic [23:0] addr;
    logic [1:0]  ptr_idx;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    int mp[4];
    bit pair;
    bit mem[2], stp[2], tgl[2], dcr[2];

    always #2 clk = ~clk;

    dptr_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xacc_stb(xacc_stb),
        .ptr_inc_stb(ptr_inc_stb), .sel_inc_stb(sel_inc_stb),
        .addr(addr), .ptr_idx(ptr_idx)
    );

    function automatic int stepv(int v, bit d);
        return d ? ((v - 1) & 32'hFFFFFF) : ((v + 1) & 32'hFFFFFF);
    endfunction

    function automatic int exp_byte(int a);
        if (a < 12) return (mp[a/3] >> (8 * (a % 3))) & 255;
        if (a == 12) return (int'(dcr[0]) << 6) | (int'(tgl[0]) << 5) | (int'(stp[0]) << 4)
                           | (int'(pair) << 3) | int'(mem[0]);
        if (a == 13) return (int'(dcr[1]) << 6) | (int'(tgl[1]) << 5) | (int'(stp[1]) << 4)
                           | int'(mem[1]);
        return 0;
    endfunction

    task automatic model(input bit we, input int a, input int wd, input bit x, input bit pi, input bit si);
        int p, i;
        if (we) begin
            if (a < 12) mp[a/3] = (mp[a/3] & ~(255 << (8 * (a % 3)))) | ((wd & 255) << (8 * (a % 3)));
            if (a == 12 || a == 13) begin
                p = a - 12;
                mem[p] = wd[0]; stp[p] = wd[4]; tgl[p] = wd[5]; dcr[p] = wd[6];
                if (p == 0) pair = wd[3];
            end
        end else begin
            p = int'(pair);
            i = p * 2 + int'(mem[p]);
            if (x && stp[p]) mp[i] = stepv(mp[i], dcr[p]);
            if (x && tgl[p]) mem[p] = ~mem[p];
            i = p * 2 + int'(mem[p]);
            if (pi) mp[i] = stepv(mp[i], dcr[p]);
            if (si) mem[p] = ~mem[p];
        end
    endtask

    task automatic cmp_out(input string r);
        int i;
        i = int'(pair) * 2 + int'(mem[pair]);
        checks++;
        if (int'(ptr_idx) != i || int'(addr) != mp[i]) begin
            errors++;
            $display("FAIL %s: idx=%0d addr=%06h expected idx=%0d addr=%06h", r, ptr_idx, addr, i, mp[i]);
        end
    endtask

    task automatic cyc(input string r, input bit we, input int a, input int wd,
                       input bit x, input bit pi, input bit si);
        reg_we = we; reg_addr = 4'(a); reg_wdata = 8'(wd);
        xacc_stb = x; ptr_inc_stb = pi; sel_inc_stb = si;
        @(posedge clk);
        model(we, a, wd, x, pi, si);
        @(negedge clk);
        reg_we = 1'b0; xacc_stb = 1'b0; ptr_inc_stb = 1'b0; sel_inc_stb = 1'b0;
        cmp_out(r);
    endtask

    task automatic wr(input string r, input int a, input int wd);
        cyc(r, 1'b1, a, wd, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic rd_all(input string r);
        for (int a = 0; a < 16; a++) begin
            reg_addr = 4'(a);
            #0.5;
            checks++;
            if (int'(reg_rdata) != exp_byte(a)) begin
                errors++;
                $display("FAIL %s: reg %0d read %02h expected %02h", r, a, reg_rdata, exp_byte(a));
            end
        end
    endtask

    task automatic wr_ptr(input string r, input int k, input int v);
        for (int b = 0; b < 3; b++) wr(r, 3 * k + b, (v >> (8 * b)) & 255);
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) mp[k] = 0;
        pair = 0;
        for (int p = 0; p < 2; p++) begin mem[p] = 0; stp[p] = 0; tgl[p] = 0; dcr[p] = 0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        cmp_out("R1");
        rd_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        cmp_out("R1");

        // R2 pointer bytes written and read back
        wr_ptr("R2", 0, 32'h123456);
        wr_ptr("R2", 1, 32'hABCDEF);
        wr_ptr("R2", 2, 32'h000010);
        wr_ptr("R2", 3, 32'hFFFFFF);
        rd_all("R2");
        wr("R2", 14, 8'hFF);
        wr("R2", 15, 8'hA5);
        rd_all("R2");

        // R3 field decode and index selection
        wr("R3", 12, 8'h81);
        rd_all("R3");
        wr("R3", 12, 8'h08);
        wr("R3", 13, 8'h0F);
        rd_all("R3");
        wr("R3", 12, 8'h00);

        // R4 stepping on access, both directions
        wr("R4", 12, 8'h10);
        repeat (3) cyc("R4", 0, 0, 0, 1, 0, 0);
        wr("R4", 12, 8'h50);
        repeat (5) cyc("R4", 0, 0, 0, 1, 0, 0);

        // R5 wrap both ways on pointer 3
        wr("R5", 12, 8'h08);
        wr("R5", 13, 8'h11);
        cyc("R5", 0, 0, 0, 1, 0, 0);
        wr("R5", 13, 8'h51);
        cyc("R5", 0, 0, 0, 1, 0, 0);
        cyc("R5", 0, 0, 0, 0, 1, 0);
        rd_all("R5");

        // R6 toggle after step on pair 0
        wr("R6", 12, 8'h30);
        repeat (4) cyc("R6", 0, 0, 0, 1, 0, 0);
        wr("R6", 12, 8'h20);
        repeat (2) cyc("R6", 0, 0, 0, 1, 0, 0);
        rd_all("R6");

        // R7 explicit increment
        wr("R7", 12, 8'h00);
        repeat (2) cyc("R7", 0, 0, 0, 0, 1, 0);
        wr("R7", 12, 8'h41);
        repeat (2) cyc("R7", 0, 0, 0, 0, 1, 0);

        // R8 select flip, pair 1 active, pair 0 member untouched
        wr("R8", 12, 8'h09);
        wr("R8", 13, 8'h00);
        repeat (3) cyc("R8", 0, 0, 0, 0, 0, 1);
        rd_all("R8");

        // R9 same-cycle ordering
        wr("R9", 12, 8'h30);
        cyc("R9", 0, 0, 0, 1, 1, 0);
        cyc("R9", 0, 0, 0, 1, 1, 1);
        wr("R9", 12, 8'h10);
        cyc("R9", 0, 0, 0, 1, 1, 0);
        cyc("R9", 0, 0, 0, 1, 1, 1);
        wr("R9", 12, 8'h70);
        cyc("R9", 0, 0, 0, 1, 1, 1);
        rd_all("R9");

        // R10 write cycle masks strobes
        wr("R10", 12, 8'h31);
        cyc("R10", 1, 15, 8'h00, 1, 1, 1);
        cyc("R10", 1, 4, 8'h77, 1, 1, 1);
        rd_all("R10");

        // R11 inactive pair controls have no effect
        wr("R11", 12, 8'h78);
        wr("R11", 13, 8'h00);
        repeat (2) cyc("R11", 0, 0, 0, 1, 0, 0);
        cyc("R11", 0, 0, 0, 0, 1, 1);
        rd_all("R11");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule